// File: doc/BRIEF.md
# ADC Multiplexer Frame Sequencer

This block produces the timing skeleton for one multiplexed analog-to-digital frame. It runs from a slow tick (one pulse per 32768 Hz period, presented as a single-clock enable on the fast system clock). Every frame lasts a fixed number of ticks. The first tick of the frame is a settling slot in which nothing is converted. The remaining ticks are split into a programmable number of conversions, each of a programmable length. For each conversion the block reports the channel index and gives a start strobe when the conversion begins and a done strobe when it ends.

Two settings describe a frame: a conversion count and a 2-bit length code. They are valid only if count times length fills exactly the ticks left after the settling slot, which is 14 of the nominal 15. With any other combination the block raises an error flag and stays idle. The settings and the enable are sampled only at a frame boundary, so software can rewrite them at any time and the change applies from the next frame. After it is enabled, the block runs frame after frame with no gap between them.

Top module: `mux_frame_seq`

## Requirements
- R1: After reset every output is 0: channel index 0, no strobes, settle low and cfg_err low.
- R2: At a tick where the block is idle or a frame ends, it starts a frame if en=1 and the configuration is valid. frame_start then pulses, settle goes high with channel index 0, and settle stays high until the next tick.
- R3: The length code c (2 bits) gives c+1 ticks per conversion, so 00, 01, 10 and 11 give 1, 2, 3 and 4 ticks. conv_start pulses at the tick that begins each conversion, which for the first conversion is the tick that ends the settling slot. conv_done pulses at the tick that ends each conversion.
- R4: chan_idx holds k during conversion k. It counts 0 to N-1 within a frame and is 0 again at the next frame start.
- R5: A frame lasts 15 ticks: one settling tick plus N×L conversion ticks. The done strobe of the last conversion falls at the same tick as the next frame_start. Where a conversion follows, it falls at the same tick as that conversion's conv_start.
- R6: A configuration is valid only when N×L equals 14, with N the 4-bit conversion count (N=0 is invalid). An invalid configuration seen at an evaluating tick with en=1 sets cfg_err and keeps the block idle: no settle, no conversion strobes.
- R7: conv_count and len_code are sampled only at a frame boundary. Changing them mid-frame does not alter the running frame.
- R8: If en=0 when a frame ends, the block completes that frame and then goes idle. While idle with en=0 it stays idle and cfg_err is 0.
- R9: conv_start, conv_done and frame_start are one clock wide. They appear in the clock cycle right after the clock edge that samples tick high.
- R10: After an error, the first evaluating tick with en=1 and a valid configuration clears cfg_err and starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock enable, one per slow-clock period |
| en | input | 1 | Sequencing enable, sampled at frame boundaries |
| conv_count | input | 4 | Conversions per frame (N) |
| len_code | input | 2 | Ticks-per-conversion code (L = code+1) |
| chan_idx | output | 4 | Index of the current conversion |
| conv_start | output | 1 | Conversion start strobe |
| conv_done | output | 1 | Conversion done strobe |
| settle | output | 1 | High during the settling slot |
| frame_start | output | 1 | Frame start strobe |
| cfg_err | output | 1 | Configuration product is not 14 while enabled |

## Verification
Two strobes must land in the same cycle in normal use. The last conv_done of a frame coincides with the next frame_start and settle, and every other conv_done coincides with the following conv_start. To check this, the bench runs frames back to back with the default (7, code 01) and the (14, code 00) settings and samples all outputs together in the cycle after each tick. It also makes an invalid setting reach a frame boundary while enabled. At that boundary conv_done must appear together with cfg_err, and neither frame_start nor settle may appear.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_CONV   = 2'd2
    } phase_e;

endpackage

// File: rtl/mfs_cfg_check.sv
// Decodes the length code and checks that count x length fills the
// conversion part of the frame.
module mfs_cfg_check #(
    parameter int CNT_W        = 4,
    parameter int LEN_W        = 2,
    parameter int ACTIVE_TICKS = 14
) (
    input  logic [CNT_W-1:0] n_conv,
    input  logic [LEN_W-1:0] len_code,
    output logic [LEN_W:0]   ticks,
    output logic             cfg_ok
);
    localparam int PROD_W = CNT_W + LEN_W + 1;

    logic [PROD_W-1:0] product;

    always_comb begin
        ticks   = (LEN_W+1)'(len_code) + (LEN_W+1)'(1);
        product = PROD_W'(n_conv) * PROD_W'(ticks);
        cfg_ok  = (product == PROD_W'(ACTIVE_TICKS));
    end

endmodule

// File: rtl/mfs_slot_ctr.sv
// Counts ticks inside one slot (settling slot or conversion); at_last
// marks the final tick of the slot, after which the count wraps to zero.
module mfs_slot_ctr #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         hold,
    input  logic [W-1:0] limit,
    output logic         at_last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        at_last = (cnt_q == limit - W'(1));
        cnt_d   = cnt_q;
        if (hold) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = at_last ? '0 : cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/mux_frame_seq.sv
module mux_frame_seq #(
    parameter int CNT_W        = 4,
    parameter int LEN_W        = 2,
    parameter int FRAME_TICKS  = 15,
    parameter int SETTLE_TICKS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic [CNT_W-1:0] conv_count,
    input  logic [LEN_W-1:0] len_code,
    output logic [CNT_W-1:0] chan_idx,
    output logic             conv_start,
    output logic             conv_done,
    output logic             settle,
    output logic             frame_start,
    output logic             cfg_err
);
    import mfs_pkg::*;

    localparam int ACTIVE_TICKS = FRAME_TICKS - SETTLE_TICKS;
    localparam int SET_W        = $clog2(SETTLE_TICKS + 1);
    localparam int SLOT_W       = (LEN_W + 1 > SET_W) ? LEN_W + 1 : SET_W;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] chan;
        logic [CNT_W-1:0] n_conv;
        logic [LEN_W:0]   ticks;
        logic             conv_start;
        logic             conv_done;
        logic             frame_start;
        logic             cfg_err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [LEN_W:0]  new_ticks;
    logic            new_ok;
    logic [SLOT_W-1:0] slot_limit;
    logic            slot_last;
    logic            boundary;

    mfs_cfg_check #(
        .CNT_W       (CNT_W),
        .LEN_W       (LEN_W),
        .ACTIVE_TICKS(ACTIVE_TICKS)
    ) u_cfg (
        .n_conv  (conv_count),
        .len_code(len_code),
        .ticks   (new_ticks),
        .cfg_ok  (new_ok)
    );

    assign slot_limit = (seq_q.phase == PH_SETTLE) ? SLOT_W'(SETTLE_TICKS)
                                                   : SLOT_W'(seq_q.ticks);

    mfs_slot_ctr #(
        .W(SLOT_W)
    ) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .hold   (seq_q.phase == PH_IDLE),
        .limit  (slot_limit),
        .at_last(slot_last)
    );

    always_comb begin
        seq_d             = seq_q;
        seq_d.conv_start  = 1'b0;
        seq_d.conv_done   = 1'b0;
        seq_d.frame_start = 1'b0;
        boundary          = 1'b0;

        case (seq_q.phase)
            PH_IDLE: begin
                boundary = tick;
            end
            PH_SETTLE: begin
                if (tick && slot_last) begin
                    seq_d.phase      = PH_CONV;
                    seq_d.chan       = '0;
                    seq_d.conv_start = 1'b1;
                end
            end
            PH_CONV: begin
                if (tick && slot_last) begin
                    seq_d.conv_done = 1'b1;
                    if (seq_q.chan == seq_q.n_conv - CNT_W'(1)) begin
                        boundary = 1'b1;
                    end else begin
                        seq_d.chan       = seq_q.chan + CNT_W'(1);
                        seq_d.conv_start = 1'b1;
                    end
                end
            end
            default: begin
                seq_d.phase = PH_IDLE;
            end
        endcase

        if (boundary) begin
            seq_d.chan = '0;
            if (en && new_ok) begin
                seq_d.phase       = PH_SETTLE;
                seq_d.n_conv      = conv_count;
                seq_d.ticks       = new_ticks;
                seq_d.frame_start = 1'b1;
                seq_d.cfg_err     = 1'b0;
            end else begin
                seq_d.phase   = PH_IDLE;
                seq_d.cfg_err = en;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign chan_idx    = seq_q.chan;
    assign conv_start  = seq_q.conv_start;
    assign conv_done   = seq_q.conv_done;
    assign settle      = (seq_q.phase == PH_SETTLE);
    assign frame_start = seq_q.frame_start;
    assign cfg_err     = seq_q.cfg_err;

endmodule

// File: rtl/mfs_checker.sv
module mfs_checker #(
    parameter int CNT_W        = 4,
    parameter int FRAME_TICKS  = 15,
    parameter int SETTLE_TICKS = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] chan_idx,
    input logic             conv_start,
    input logic             conv_done,
    input logic             settle,
    input logic             frame_start,
    input logic             cfg_err
);
    localparam int ACTIVE_TICKS = FRAME_TICKS - SETTLE_TICKS;

    p_frame_start_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (settle && chan_idx == '0));

    p_settle_one_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((SETTLE_TICKS == 1) && settle && tick) |=> !settle);

    p_start_not_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !settle);

    p_chan_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(chan_idx) < ACTIVE_TICKS);

    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!settle && !conv_start && !frame_start));

    p_strobe_after_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start || conv_done || frame_start) |-> $past(tick));

endmodule

bind mux_frame_seq mfs_checker #(
    .CNT_W       (CNT_W),
    .FRAME_TICKS (FRAME_TICKS),
    .SETTLE_TICKS(SETTLE_TICKS)
) u_mfs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .chan_idx   (chan_idx),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .settle     (settle),
    .frame_start(frame_start),
    .cfg_err    (cfg_err)
);

// File: tb/mux_frame_seq_test.sv
`timescale 1ns/1ps
module mux_frame_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       en = 1'b0;
    logic [3:0] conv_count = 4'd7;
    logic [1:0] len_code = 2'b01;
    logic [3:0] chan_idx;
    logic       conv_start, conv_done, settle, frame_start, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mux_frame_seq uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en),
        .conv_count(conv_count), .len_code(len_code),
        .chan_idx(chan_idx), .conv_start(conv_start), .conv_done(conv_done),
        .settle(settle), .frame_start(frame_start), .cfg_err(cfg_err)
    );

    // Compare all outputs at once; fields: fs, settle, cs, cd, chan, err
    task automatic check(string req, logic efs, logic eset, logic ecs,
                         logic ecd, int echan, logic eerr);
        logic [8:0] act, exp;
        act = {frame_start, settle, conv_start, conv_done, chan_idx, cfg_err};
        exp = {efs, eset, ecs, ecd, 4'(echan), eerr};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: fs/set/cs/cd/chan/err actual=%b expected=%b",
                     req, act, exp);
        end
    endtask

    // One tick pulse; outputs are sampled in the cycle after the sampling
    // edge, then strobes are checked clear one cycle later (R9).
    task automatic pulse_tick(string req, logic efs, logic eset, logic ecs,
                              logic ecd, int echan, logic eerr);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        check(req, efs, eset, ecs, ecd, echan, eerr);
        @(negedge clk);
        checks++;
        if ({conv_start, conv_done, frame_start} !== 3'b000) begin
            errors++;
            $display("FAIL R9 strobe width: actual=%b expected=000",
                     {conv_start, conv_done, frame_start});
        end
        @(negedge clk);
    endtask

    task automatic conv_body(string req, int n, int len);
        for (int k = 0; k < n; k++) begin
            for (int t = 0; t < len; t++) begin
                pulse_tick(req, 1'b0, 1'b0, (t == 0), (t == 0 && k > 0), k, 1'b0);
            end
        end
    endtask

    task automatic set_cfg(logic e, int n, int code);
        @(negedge clk);
        en = e; conv_count = 4'(n); len_code = 2'(code);
    endtask

    task automatic t_reset;
        check("R1 reset state", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_disabled;
        set_cfg(1'b0, 7, 1);
        pulse_tick("R8 disabled stays idle", 0, 0, 0, 0, 0, 0);
        pulse_tick("R8 disabled stays idle again", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_frames;
        set_cfg(1'b1, 7, 1);
        pulse_tick("R2 first frame start", 1, 1, 0, 0, 0, 0);
        // mid-frame rewrite must not affect the running frame
        set_cfg(1'b1, 14, 0);
        conv_body("R3 R4 R7 seven conversions of two ticks", 7, 2);
        pulse_tick("R5 last done meets next frame start", 1, 1, 0, 1, 0, 0);
        conv_body("R3 R4 fourteen conversions of one tick", 14, 1);
        set_cfg(1'b1, 7, 1);
        pulse_tick("R5 R7 boundary picks new setting", 1, 1, 0, 1, 0, 0);
        set_cfg(1'b0, 7, 1);
        conv_body("R8 frame completes after disable", 7, 2);
        pulse_tick("R8 idle after disabled boundary", 0, 0, 0, 1, 0, 0);
        pulse_tick("R8 remains idle", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_bad_cfg;
        set_cfg(1'b1, 5, 2);
        pulse_tick("R6 product 15 rejected", 0, 0, 0, 0, 0, 1);
        set_cfg(1'b1, 7, 3);
        pulse_tick("R6 product 28 rejected", 0, 0, 0, 0, 0, 1);
        set_cfg(1'b1, 0, 1);
        pulse_tick("R6 zero count rejected", 0, 0, 0, 0, 0, 1);
        set_cfg(1'b1, 14, 0);
        pulse_tick("R10 recovery starts frame", 1, 1, 0, 0, 0, 0);
        set_cfg(1'b1, 3, 1);
        conv_body("R7 bad rewrite ignored mid-frame", 14, 1);
        pulse_tick("R6 done with error at boundary", 0, 0, 0, 1, 0, 1);
        set_cfg(1'b0, 3, 1);
        pulse_tick("R8 error clears when disabled", 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_frames();
        t_bad_cfg();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule